// File: doc/BRIEF.md
# Multi-Lane 12-Bit Sample Unpacker

This block sits behind the link layer of a high-speed converter receive path. Every link clock it takes one 512-bit word, made of sixteen 32-bit lane words, and rebuilds the 12-bit converter samples packed in it. A frame spans two consecutive link clocks and carries 80 samples, S0 to S79. One sample in every lane is split across the two clocks of a frame. Its top 8 bits ride in the first word and its bottom 4 bits in the second, so the block holds the first part until the second part arrives.

The output is a 480-bit bus that holds 40 samples, with a valid flag. The first output group of each frame holds S0 to S39 and the next group holds S40 to S79. A frame-start marker forces the phase back to the first word of a frame. Idle clocks are allowed between frames. They do not advance the phase, and they show up on the output valid flag after the same delay as data.

Top module: `sample_unpacker`

## Requirements
- R1: While reset is asserted and after it is released, `outValid` is 0 and `outData` is all zeros until the first data reaches the output.
- R2: A word sampled with `inValid` high at rising edge n sets `outValid` high after edge n+2, which is the third edge counting the capture edge. A word sampled with `inValid` low sets `outValid` low after the same edge.
- R3: The output group produced for the first word of a frame carries S0..S39. Sample Sj sits in `outData[479-12j -: 12]`, so the lowest-numbered sample occupies the top 12 bits.
- R4: The output group produced for the second word of a frame carries S40..S79. S(40+j) sits in `outData[479-12j -: 12]`.
- R5: Lane n is `inData[32n+31:32n]`. Its base sample b is 2n for lanes 0..7 and 2(n-8)+1 for lanes 8..15, and the lane carries b, b+16, b+32, b+48 and b+64. In the first word of a frame, bits 31:20 hold sample b and bits 19:8 hold sample b+16.
- R6: Sample b+32 takes its upper 8 bits from bits 7:0 of the lane in the first word and its lower 4 bits from bits 31:28 of the lane in the second word. In the second word, bits 27:16 hold b+48 and bits 15:4 hold b+64.
- R7: Bits 3:0 of each lane in the second word of a frame have no effect on the output.
- R8: A valid word presented with `frameStart` high is treated as the first word of a frame, whatever the phase was before. Its group appears two edges after its capture edge plus one, as in R2, and holds S0..S39 of that frame.
- R9: Without `frameStart`, the phase alternates first/second on each valid word. Clocks with `inValid` low do not change it.
- R10: While `outValid` is low, `outData` keeps the value it last held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inData | input | 512 | Sixteen 32-bit lane words, lane n at bits 32n+31:32n |
| inValid | input | 1 | The word on `inData` is valid this clock |
| frameStart | input | 1 | The current valid word is the first of a frame |
| outData | output | 480 | 40 samples, lowest-numbered sample in the top 12 bits |
| outValid | output | 1 | `outData` holds a fresh group of samples |

## Verification
The bench targets the split sample b+32 with all-ones, all-zeros, alternating and ramp patterns. A design that mixed up the halves, or took the lower 4 bits from the wrong word, would corrupt S32..S47 only, and the bench compares every sample. The second-word tail bits are filled with values that change from frame to frame, so any leak of them into S64..S79 shows up as a mismatch. The bench abandons a half-sent frame and restarts it with the marker, which catches a phase that ignores the marker: the second-half groups would then come out swapped. It also inserts idle gaps between frames sent without a marker, which catches a phase that advances on idle clocks. Every idle output clock is checked for a held bus and a low valid flag.

// File: rtl/unpack_pkg.sv
package unpack_pkg;
  // Packing geometry of one lane word.
  localparam int SAMP_W    = 12;
  localparam int LANE_W    = 32;
  localparam int SPLIT_HI  = 8;   // bits of the straddling sample in the first word
  localparam int SPLIT_LO  = SAMP_W - SPLIT_HI;
  localparam int PER_LANE  = 5;   // samples per lane per frame

  // Strobes from control to datapath.
  typedef struct packed {
    logic holdCarry;  // stage-1 word is a first word: keep its split bits
    logic emitLow;    // stage-2 word is a first word: produce first half
    logic emitHigh;   // stage-2 word is a second word: produce second half
  } strobe_t;
endpackage

// File: rtl/unpack_ctrl.sv
module unpack_ctrl
  import unpack_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    inValid,
  input  logic    frameStart,
  output strobe_t strb,
  output logic    outValid
);
  logic phaseReg;
  logic curPhase;
  logic v1, p1, v2, p2;

  // 0 = first word of a frame, 1 = second word
  assign curPhase = frameStart ? 1'b0 : phaseReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseReg <= 1'b0;
      v1       <= 1'b0;
      p1       <= 1'b0;
      v2       <= 1'b0;
      p2       <= 1'b0;
      outValid <= 1'b0;
    end else begin
      if (inValid) phaseReg <= ~curPhase;
      v1       <= inValid;
      p1       <= curPhase;
      v2       <= v1;
      p2       <= p1;
      outValid <= v2;
    end
  end

  always_comb begin
    strb.holdCarry = v1 & ~p1;
    strb.emitLow   = v2 & ~p2;
    strb.emitHigh  = v2 &  p2;
  end
endmodule

// File: rtl/unpack_datapath.sv
module unpack_datapath
  import unpack_pkg::*;
#(
  parameter int LANES = 16
) (
  input  logic                                     clk,
  input  logic                                     rstN,
  input  logic [LANES*LANE_W-1:0]                  inData,
  input  strobe_t                                  strb,
  output logic [(PER_LANE*LANES/2)*SAMP_W-1:0]     outData
);
  localparam int IN_W      = LANES * LANE_W;
  localparam int HALF_LN   = LANES / 2;
  localparam int HALF_SMP  = PER_LANE * LANES / 2;
  localparam int OUT_W     = HALF_SMP * SAMP_W;

  logic [IN_W-1:0]           s1Data, s2Data;
  logic [LANES*SPLIT_HI-1:0] carry;
  logic [OUT_W-1:0]          lowWord, highWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Data <= '0;
      s2Data <= '0;
    end else begin
      s1Data <= inData;
      s2Data <= s1Data;
    end
  end

  generate
    for (genvar ln = 0; ln < LANES; ln++) begin : gLane
      localparam int BASE  = (ln < HALF_LN) ? 2*ln : 2*(ln-HALF_LN)+1;
      localparam int LO    = ln * LANE_W;
      // output slot p occupies bits starting at (HALF_SMP-1-p)*SAMP_W
      localparam int POS_A = (HALF_SMP-1-BASE) * SAMP_W;
      localparam int POS_B = (HALF_SMP-1-(BASE+LANES)) * SAMP_W;
      localparam int POS_D = (HALF_SMP-1-(BASE+3*LANES-HALF_SMP)) * SAMP_W;
      localparam int POS_E = (HALF_SMP-1-(BASE+4*LANES-HALF_SMP)) * SAMP_W;

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)               carry[ln*SPLIT_HI +: SPLIT_HI] <= '0;
        else if (strb.holdCarry) carry[ln*SPLIT_HI +: SPLIT_HI] <= s1Data[LO +: SPLIT_HI];
      end

      assign lowWord[POS_A +: SAMP_W] = s2Data[LO+20 +: SAMP_W];
      assign lowWord[POS_B +: SAMP_W] = s2Data[LO+8  +: SAMP_W];

      if (BASE < HALF_LN) begin : gSplitLow
        localparam int POS_C = (HALF_SMP-1-(BASE+2*LANES)) * SAMP_W;
        // straddling sample belongs to the first half: next word is in stage 1
        assign lowWord[POS_C +: SAMP_W] =
          {s2Data[LO +: SPLIT_HI], s1Data[LO+LANE_W-SPLIT_LO +: SPLIT_LO]};
      end else begin : gSplitHigh
        localparam int POS_C = (HALF_SMP-1-(BASE+2*LANES-HALF_SMP)) * SAMP_W;
        // straddling sample belongs to the second half: upper bits were held
        assign highWord[POS_C +: SAMP_W] =
          {carry[ln*SPLIT_HI +: SPLIT_HI], s2Data[LO+LANE_W-SPLIT_LO +: SPLIT_LO]};
      end

      assign highWord[POS_D +: SAMP_W] = s2Data[LO+16 +: SAMP_W];
      assign highWord[POS_E +: SAMP_W] = s2Data[LO+4  +: SAMP_W];
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              outData <= '0;
    else if (strb.emitLow)  outData <= lowWord;
    else if (strb.emitHigh) outData <= highWord;
  end
endmodule

// File: rtl/sample_unpacker.sv
module sample_unpacker
  import unpack_pkg::*;
#(
  parameter int LANES = 16
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  logic [LANES*LANE_W-1:0]              inData,
  input  logic                                 inValid,
  input  logic                                 frameStart,
  output logic [(PER_LANE*LANES/2)*SAMP_W-1:0] outData,
  output logic                                 outValid
);
  strobe_t strb;

  unpack_ctrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .inValid    (inValid),
    .frameStart (frameStart),
    .strb       (strb),
    .outValid   (outValid)
  );

  unpack_datapath #(.LANES(LANES)) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .inData  (inData),
    .strb    (strb),
    .outData (outData)
  );
endmodule

// File: rtl/unpacker_checker.sv
module unpacker_checker #(
  parameter int OUT_W = 480
) (
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic             frameStart,
  input logic             outValid,
  input logic [OUT_W-1:0] outData,
  input logic             emitLow,
  input logic             emitHigh
);
  logic [1:0] sinceReset;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 sinceReset <= '0;
    else if (sinceReset != 3)  sinceReset <= sinceReset + 2'd1;
  end

  // R2: output valid follows input valid three edges later
  assert_valid_latency_R2: assert property (@(posedge clk) disable iff (!rstN)
    (sinceReset == 2'd3) |-> (outValid == $past(inValid, 3)));

  // R4: a second-half group is always preceded by a first-half group
  assert_half_order_R4: assert property (@(posedge clk) disable iff (!rstN)
    (sinceReset != 2'd0 && emitHigh) |-> $past(emitLow));

  // R8: a marked word produces a first-half group
  assert_marker_resync_R8: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && frameStart) |=> ##1 emitLow);

  // R10: bus holds while not valid
  assert_hold_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    (sinceReset != 2'd0 && !outValid) |-> $stable(outData));
endmodule

bind sample_unpacker unpacker_checker #(
  .OUT_W((unpack_pkg::PER_LANE*LANES/2)*unpack_pkg::SAMP_W)
) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .inValid    (inValid),
  .frameStart (frameStart),
  .outValid   (outValid),
  .outData    (outData),
  .emitLow    (strb.emitLow),
  .emitHigh   (strb.emitHigh)
);

// File: tb/tb_sample_unpacker.sv
module tb_sample_unpacker;
  localparam int LANES = 16;
  localparam int IN_W  = LANES * 32;
  localparam int HS    = 40;
  localparam int OUT_W = HS * 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [IN_W-1:0] inData = '0;
  logic inValid = 1'b0;
  logic frameStart = 1'b0;
  wire  [OUT_W-1:0] outData;
  wire  outValid;

  always #5 clk = ~clk;

  sample_unpacker #(.LANES(LANES)) dut (
    .clk(clk), .rstN(rstN), .inData(inData), .inValid(inValid),
    .frameStart(frameStart), .outData(outData), .outValid(outValid)
  );

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic             qV[$];
  bit               qC[$];
  logic [OUT_W-1:0] qD[$];
  string            qT[$];
  logic [OUT_W-1:0] lastOut = '0;
  bit               lastKnown = 1'b1;

  function automatic logic [11:0] sampleVal(int f, int s);
    if (f == 2) return 12'hFFF;
    if (f == 3) return 12'h000;
    if (f == 4) return (s % 2 == 0) ? 12'hA5A : 12'h5A5;
    return 12'((f * 131 + s * 29 + 7) & 12'hFFF);
  endfunction

  // inverse mapping: frame f, word ph (0 first, 1 second)
  function automatic logic [IN_W-1:0] packWord(int f, int ph);
    logic [IN_W-1:0] w = '0;
    for (int n = 0; n < LANES; n++) begin
      int b = (n < LANES/2) ? 2*n : 2*(n-LANES/2)+1;
      logic [11:0] c = sampleVal(f, b+32);
      if (ph == 0)
        w[n*32 +: 32] = {sampleVal(f, b), sampleVal(f, b+16), c[11:4]};
      else
        w[n*32 +: 32] = {c[3:0], sampleVal(f, b+48), sampleVal(f, b+64),
                         4'((f*3 + n*5 + 1) & 15)};
    end
    return w;
  endfunction

  function automatic logic [OUT_W-1:0] halfBus(int f, int h);
    logic [OUT_W-1:0] d = '0;
    for (int j = 0; j < HS; j++) d[OUT_W-1-12*j -: 12] = sampleVal(f, HS*h + j);
    return d;
  endfunction

  task automatic checkFront();
    logic ev = qV.pop_front();
    bit ec = qC.pop_front();
    logic [OUT_W-1:0] ed = qD.pop_front();
    string tg = qT.pop_front();
    checks++;
    if (outValid !== ev) begin
      failures++;
      $display("FAIL R2: outValid=%0b expected=%0b", outValid, ev);
    end
    if (ev && ec) begin
      checks++;
      if (outData !== ed) begin
        failures++;
        $display("FAIL %s: outData=%h expected=%h", tg, outData, ed);
      end
      lastOut = ed;
      lastKnown = 1'b1;
    end else if (ev) begin
      lastKnown = 1'b0;
    end else if (lastKnown) begin
      checks++;
      if (outData !== lastOut) begin
        failures++;
        $display("FAIL R10: outData=%h expected=%h", outData, lastOut);
      end
    end
  endtask

  task automatic step(bit v, bit m, logic [IN_W-1:0] d, bit chk,
                      logic [OUT_W-1:0] e, string tag);
    @(negedge clk);
    if (qV.size() == 3) checkFront();
    inValid = v; frameStart = m; inData = d;
    qV.push_back(v); qC.push_back(chk); qD.push_back(e); qT.push_back(tag);
  endtask

  task automatic sendFrame(int f, bit m, string tag);
    step(1'b1, m,    packWord(f, 0), 1'b1, halfBus(f, 0), {"R3 R5 R6 ", tag});
    step(1'b1, 1'b0, packWord(f, 1), 1'b1, halfBus(f, 1), {"R4 R6 R7 ", tag});
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++)
      step(1'b0, 1'b0, {LANES{32'hDEADBEEF}}, 1'b0, '0, "R10");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checks++;  // R1 during reset
    if (outValid !== 1'b0 || outData !== '0) begin
      failures++;
      $display("FAIL R1: outValid=%0b outData=%h expected=0 and 0", outValid, outData);
    end
    rstN = 1'b1;
    @(negedge clk);
    checks++;  // R1 after release
    if (outValid !== 1'b0 || outData !== '0) begin
      failures++;
      $display("FAIL R1: outValid=%0b outData=%h expected=0 and 0", outValid, outData);
    end

    sendFrame(0, 1'b1, "R8");
    sendFrame(1, 1'b0, "R9");
    sendFrame(2, 1'b0, "R9");
    idle(2);
    sendFrame(3, 1'b0, "R9");
    idle(1);
    sendFrame(4, 1'b0, "R9");
    // abandoned first word, then a marked restart (R8)
    step(1'b1, 1'b0, packWord(5, 0), 1'b0, '0, "R8");
    sendFrame(6, 1'b1, "R8");
    for (int f = 7; f < 20; f++) sendFrame(f, 1'b0, "R9");
    idle(3);
    sendFrame(20, 1'b1, "R8");
    idle(4);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: run did not finish expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule